// File: doc/BRIEF.md
# Memory-mapped GPIO bank with atomic set/clear output latch

This block is one bank of general-purpose pins behind a simple register strobe. Software reads a synchronised input word, and it changes the output latch only by writing a mask to a set word or to a clear word. A one in the mask sets or clears that latch bit. A zero leaves the bit as it is. Because of this, two agents can update different pins without a read-modify-write.

Each pin has its own configuration word with four fields: a drive enable, a polarity invert, an open-drain mode, and a 10-bit alternate-function selector. The block drives a per-pin output enable and output value toward the pad, and it receives the raw pad level. The pin stays under GPIO control only while its selector is zero. The bank also exposes a constant word that reports the pin count and an interrupt vector base.

Bus access runs through a two-state machine. In `ST_IDLE` the bank accepts a request. A write takes effect at the accepting edge and the machine stays in `ST_IDLE`. A read moves the machine to `ST_RESP` (transition "read accepted"). There it presents the captured data for exactly one cycle, then returns to `ST_IDLE` (transition "response delivered"). While the machine is in `ST_RESP`, requests are not accepted.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin_oe and pin_out bit is 0, req_ready is 1, rsp_valid is 0, the output latch is 0 and every configuration word is 0.
- R2: An accepted write to byte offset 0x008 sets each latch bit whose mask bit is 1 and leaves the other latch bits unchanged.
- R3: An accepted write to byte offset 0x010 clears each latch bit whose mask bit is 1 and leaves the other latch bits unchanged.
- R4: A read of offset 0x008 returns the latch in bits NPINS-1:0 with zeros above. A read of offset 0x010 returns zero.
- R5: A read of offset 0x000 returns, for each pin, the pad level sampled through a two-flop synchroniser XOR that pin's invert bit. A write to 0x000 has no effect.
- R6: The configuration word of pin i sits at offset 0x400 + 8*i. Its fields are bit 0 drive enable, bit 1 invert, bit 12 open-drain, and bits 25:16 alternate selector. A read returns exactly these fields, with all other bits zero.
- R7: For a GPIO pin in push-pull mode (open-drain 0), pin_oe equals the drive enable and pin_out equals the latch bit XOR invert.
- R8: For a GPIO pin in open-drain mode, pin_out is 0 and pin_oe is the drive enable AND NOT (latch bit XOR invert).
- R9: For a pin whose alternate selector is nonzero, pin_oe and pin_out are both 0.
- R10: A read of offset 0x090 returns NPINS in bits 7:0 and VEC_BASE in bits 15:8, with all other bits zero.
- R11: The bank ignores mask bits at or above NPINS. A read of an unmapped, misaligned or out-of-range address returns zero, and a write to such an address changes nothing.
- R12: A read accepted in ST_IDLE raises rsp_valid for exactly the next cycle, together with its data. req_ready is low during that cycle, and a request presented then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| pin_in | input | NPINS | Raw pad levels |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |

## Verification
A write is accepted at one clock edge, and its effect on pin_oe and pin_out is due just after that same edge. The bench therefore samples the pin outputs on the falling edge that follows. Read data and rsp_valid appear one edge after acceptance, and a pad change reaches the input word only after two further edges. The bench's behavioural model advances on the same rising edges with these delays built in, and every falling edge compares all pins, the handshake and any response against the model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 64;

    localparam logic [ADDR_W-1:0] OFF_RXDAT = 13'h000;
    localparam logic [ADDR_W-1:0] OFF_SET   = 13'h008;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 13'h010;
    localparam logic [ADDR_W-1:0] OFF_INFO  = 13'h090;
    // configuration window 0x400..0x5FF: address bits 12:9 equal 4'h2
    localparam logic [3:0]        CFG_WIN   = 4'h2;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    typedef struct packed {
        logic [9:0] alt_sel;
        logic       od_en;
        logic       inv_en;
        logic       oe_en;
    } pin_cfg_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.oe_en;
        w[1]     = c.inv_en;
        w[12]    = c.od_en;
        w[25:16] = c.alt_sel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= raw_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wr,
    input  logic     set_hit,
    input  logic     clr_hit,
    input  logic     pad_sync,
    output logic     pad_oe,
    output logic     pad_out,
    output pin_cfg_t cfg_q,
    output logic     latch_q,
    output logic     rx_bit
);

    logic eff_data;
    logic alt_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (clr_hit) latch_q <= 1'b0;
        else if (set_hit) latch_q <= 1'b1;
    end

    always_comb begin
        eff_data   = latch_q ^ cfg_q.inv_en;
        alt_active = |cfg_q.alt_sel;
        rx_bit     = pad_sync ^ cfg_q.inv_en;
        if (alt_active) begin
            pad_oe  = 1'b0;
            pad_out = 1'b0;
        end else if (cfg_q.od_en) begin
            pad_oe  = cfg_q.oe_en & ~eff_data;
            pad_out = 1'b0;
        end else begin
            pad_oe  = cfg_q.oe_en;
            pad_out = eff_data;
        end
    end

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
#(
    parameter int         NPINS    = 16,
    parameter logic [7:0] VEC_BASE = 8'h30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [NPINS-1:0]        rx_word,
    input  logic [NPINS-1:0]        latch_word,
    input  pin_cfg_t [NPINS-1:0]    cfg_all,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic [NPINS-1:0]        set_mask,
    output logic [NPINS-1:0]        clr_mask,
    output logic [NPINS-1:0]        cfg_we,
    output pin_cfg_t                cfg_wr
);

    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    bus_state_e        state_q, state_d;
    logic              accept;
    logic              aligned;
    logic [5:0]        cfg_idx;
    logic              cfg_hit;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rsp_data_q;
    logic              unused_wbits;

    assign unused_wbits = ^req_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin req_ready = 1'b1; rsp_valid = 1'b0; end
            ST_RESP: begin req_ready = 1'b0; rsp_valid = 1'b1; end
        endcase
    end

    // address decode
    always_comb begin
        accept  = req_valid && (state_q == ST_IDLE);
        aligned = (req_addr[2:0] == 3'b000);
        cfg_idx = req_addr[8:3];
        cfg_hit = aligned && (req_addr[12:9] == CFG_WIN) &&
                  ({1'b0, cfg_idx} < 7'(NPINS));
    end

    // write strobes
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        cfg_we   = '0;
        cfg_wr   = '{alt_sel: req_wdata[25:16], od_en: req_wdata[12],
                     inv_en: req_wdata[1], oe_en: req_wdata[0]};
        if (accept && req_write) begin
            if (req_addr == OFF_SET) set_mask = req_wdata[NPINS-1:0];
            if (req_addr == OFF_CLR) clr_mask = req_wdata[NPINS-1:0];
            if (cfg_hit)             cfg_we[cfg_idx[IDX_W-1:0]] = 1'b1;
        end
    end

    // read selection
    always_comb begin
        rd_word = '0;
        if (cfg_hit) begin
            rd_word = cfg_to_word(cfg_all[cfg_idx[IDX_W-1:0]]);
        end else if (req_addr == OFF_RXDAT) begin
            rd_word[NPINS-1:0] = rx_word;
        end else if (req_addr == OFF_SET) begin
            rd_word[NPINS-1:0] = latch_word;
        end else if (req_addr == OFF_INFO) begin
            rd_word[7:0]  = 8'(NPINS);
            rd_word[15:8] = VEC_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rsp_data_q <= '0;
        else if (accept && !req_write)   rsp_data_q <= rd_word;
    end

    assign rsp_data = rsp_data_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int         NPINS       = 16,
    parameter logic [7:0] VEC_BASE    = 8'h30,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [12:0]       req_addr,
    input  logic [63:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out
);

    logic [NPINS-1:0]     pin_sync;
    logic [NPINS-1:0]     rx_word;
    logic [NPINS-1:0]     latch_q;
    logic [NPINS-1:0]     set_mask;
    logic [NPINS-1:0]     clr_mask;
    logic [NPINS-1:0]     cfg_we;
    logic [NPINS-1:0]     od_vec;
    logic [NPINS-1:0]     oe_vec;
    logic [NPINS-1:0]     alt_vec;
    pin_cfg_t             cfg_wr;
    pin_cfg_t [NPINS-1:0] cfg_all;

    gpio_in_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bus_fsm #(
        .NPINS    (NPINS),
        .VEC_BASE (VEC_BASE)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rx_word    (rx_word),
        .latch_word (latch_q),
        .cfg_all    (cfg_all),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .cfg_we     (cfg_we),
        .cfg_wr     (cfg_wr)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[i]),
            .cfg_wr   (cfg_wr),
            .set_hit  (set_mask[i]),
            .clr_hit  (clr_mask[i]),
            .pad_sync (pin_sync[i]),
            .pad_oe   (pin_oe[i]),
            .pad_out  (pin_out[i]),
            .cfg_q    (cfg_all[i]),
            .latch_q  (latch_q[i]),
            .rx_bit   (rx_word[i])
        );
        assign od_vec[i]  = cfg_all[i].od_en;
        assign oe_vec[i]  = cfg_all[i].oe_en;
        assign alt_vec[i] = |cfg_all[i].alt_sel;
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [12:0]       req_addr,
    input logic [63:0]       req_wdata,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  latch_q,
    input logic [NPINS-1:0]  od_vec,
    input logic [NPINS-1:0]  oe_vec,
    input logic [NPINS-1:0]  alt_vec
);

    logic wr_acc;
    assign wr_acc = req_valid && req_ready && req_write;

    // R2: set mask bits are 1 in the latch after the accepting edge
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && req_addr == OFF_SET) |=>
        ((latch_q & $past(req_wdata[NPINS-1:0])) == $past(req_wdata[NPINS-1:0])));

    // R3: clear mask bits are 0 in the latch after the accepting edge
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && req_addr == OFF_CLR) |=>
        ((latch_q & $past(req_wdata[NPINS-1:0])) == '0));

    // R11: latch holds unless a set or clear write is accepted
    a_r11_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && (req_addr == OFF_SET || req_addr == OFF_CLR)) |=> $stable(latch_q));

    // R12: accepted read answers next cycle, response lasts one cycle
    a_r12_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);
    a_r12_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r12_not_ready_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8: an open-drain pin never drives a one
    a_r8_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & od_vec) == '0);

    // R9: alternate-function pins are released
    a_r9_alt_released: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & alt_vec) == '0);

    // R7: no pin drives without its enable
    a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~oe_vec) == '0);

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .latch_q   (latch_q),
    .od_vec    (od_vec),
    .oe_vec    (oe_vec),
    .alt_vec   (alt_vec)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

    localparam int         NP = 16;
    localparam logic [7:0] VB = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_out;

    always #10 clk = ~clk;

    gpio_bank #(.NPINS(NP), .VEC_BASE(VB)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    chk_en = 0;
    bit    ended = 0;
    string rd_tag = "R4";

    // behavioural reference state
    bit [NP-1:0] m_latch, m_oe, m_inv, m_od, m_s1, m_s2;
    bit [9:0]    m_alt [NP];
    bit          m_busy, m_rsp_valid;
    bit [63:0]   m_rsp_data;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit [63:0] model_read(input bit [12:0] a);
        int ai;
        bit [63:0] v;
        ai = int'(a);
        v  = '0;
        if (ai % 8 != 0) return v;
        if (ai == 0)            v[NP-1:0] = m_s2 ^ m_inv;
        else if (ai == 8)       v[NP-1:0] = m_latch;
        else if (ai == 'h90)    v = {48'd0, VB, 8'(NP)};
        else if (ai >= 'h400 && ai < 'h400 + 8*NP) begin
            int k;
            k = (ai - 'h400) / 8;
            v[0] = m_oe[k]; v[1] = m_inv[k]; v[12] = m_od[k]; v[25:16] = m_alt[k];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch = '0; m_oe = '0; m_inv = '0; m_od = '0; m_s1 = '0; m_s2 = '0;
            for (int i = 0; i < NP; i++) m_alt[i] = '0;
            m_busy = 0; m_rsp_valid = 0; m_rsp_data = '0;
        end else begin
            bit acc;
            int ai;
            acc = req_valid && !m_busy;
            ai  = int'(req_addr);
            if (acc && !req_write) m_rsp_data = model_read(req_addr);
            if (acc && req_write) begin
                if (ai == 8)       m_latch = m_latch | req_wdata[NP-1:0];
                else if (ai == 16) m_latch = m_latch & ~req_wdata[NP-1:0];
                else if (ai % 8 == 0 && ai >= 'h400 && ai < 'h400 + 8*NP) begin
                    int k;
                    k = (ai - 'h400) / 8;
                    m_oe[k] = req_wdata[0]; m_inv[k] = req_wdata[1];
                    m_od[k] = req_wdata[12]; m_alt[k] = req_wdata[25:16];
                end
            end
            m_busy      = acc && !req_write;
            m_rsp_valid = m_busy;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (chk_en && !ended) begin
            for (int i = 0; i < NP; i++) begin
                bit e, xo, xd;
                string t;
                e = m_latch[i] ^ m_inv[i];
                if (m_alt[i] != 0) begin xo = 0; xd = 0; t = "R9"; end
                else if (m_od[i])  begin xo = m_oe[i] & ~e; xd = 0; t = "R8"; end
                else               begin xo = m_oe[i]; xd = e; t = "R7"; end
                chk({t, " pin_oe"}, 64'(pin_oe[i]), 64'(xo));
                chk({t, " pin_out"}, 64'(pin_out[i]), 64'(xd));
            end
            chk("R12 req_ready", 64'(req_ready), 64'(!m_busy));
            chk("R12 rsp_valid", 64'(rsp_valid), 64'(m_rsp_valid));
            if (m_rsp_valid) chk({rd_tag, " rsp_data"}, rsp_data, m_rsp_data);
        end
    end

    task automatic wr(input logic [12:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd(input logic [12:0] a, input string tag);
        @(negedge clk);
        rd_tag = tag;
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic [12:0] cfg_addr(input int k);
        return 13'('h400 + 8*k);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);
        chk("R1 pin_out", 64'(pin_out), 64'd0);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk_en = 1;
        rd(13'h008, "R1");
        rd(cfg_addr(3), "R1");

        // R7 push-pull pins 0..3, R2 set, R3 clear
        for (int k = 0; k < 4; k++) wr(cfg_addr(k), 64'h1);
        wr(13'h008, 64'h5);
        rd(13'h008, "R2");
        wr(13'h008, 64'h2);
        wr(13'h010, 64'h1);
        rd(13'h008, "R3");
        rd(13'h010, "R4");

        // R7 invert, R8 open-drain with and without invert
        wr(cfg_addr(1), 64'h3);
        wr(cfg_addr(2), 64'h1001);
        wr(cfg_addr(3), 64'h1003);
        wr(13'h008, 64'hC);
        wr(13'h010, 64'h4);
        wr(13'h010, 64'h8);
        // R9 alternate selector
        wr(cfg_addr(4), 64'h0005_0001);
        wr(13'h008, 64'h10);
        rd(cfg_addr(4), "R6");
        // R6 reserved bits read as zero
        wr(cfg_addr(5), 64'hFFFF_FFFF_FFFF_FFFF);
        rd(cfg_addr(5), "R6");
        wr(cfg_addr(5), 64'h0);

        // R5 input word through synchroniser and invert
        pin_in = 16'hA5C3;
        idle(3);
        rd(13'h000, "R5");
        wr(13'h000, 64'hFFFF);
        rd(13'h000, "R5");
        pin_in = 16'h0F0F;
        idle(3);
        rd(13'h000, "R5");

        // R10 constant word
        rd(13'h090, "R10");

        // R11 high mask bits, misaligned, out of range
        wr(13'h008, 64'hFFFF_0000_0000_0000);
        rd(13'h008, "R11");
        wr(13'h404, 64'h1);
        wr(cfg_addr(20), 64'h1);
        rd(13'h404, "R11");
        rd(cfg_addr(20), "R11");
        rd(cfg_addr(0), "R11");
        rd(13'h018, "R11");

        // R12 request while responding is ignored
        @(negedge clk);
        rd_tag = "R12";
        req_valid = 1; req_write = 0; req_addr = 13'h008;
        @(negedge clk);
        req_write = 1; req_addr = 13'h008; req_wdata = 64'hFFFF;
        @(negedge clk);
        req_valid = 0;
        rd(13'h008, "R12");

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 8);
            if (n % 5 == 0) pin_in = NP'($urandom);
            case (op)
                0: wr(13'h008, {$urandom, $urandom});
                1: wr(13'h010, {$urandom, $urandom});
                2: wr(cfg_addr(int'($urandom % NP)),
                      64'({$urandom % 2, 13'd0, 2'($urandom)} << 11) |
                      64'($urandom % 4) | (($urandom % 4 == 0) ? 64'h1_0000 : 64'h0));
                3: rd(13'h000, "R5");
                4: rd(13'h008, "R4");
                5: rd(cfg_addr(int'($urandom % NP)), "R6");
                6: rd(13'(($urandom % 'h200) & 'h1F8), "R11");
                default: idle(1);
            endcase
        end
        idle(4);
        finish_run();
    end

endmodule